// File: doc/BRIEF.md
# Software Interrupt Redirection Unit

This unit decides where a software interrupt instruction goes when the processor runs a guest task in virtual-machine mode. For each request it receives the 8-bit interrupt vector, the current I/O privilege level, a virtual-machine mode flag, the enable for the virtual-machine extensions and the base address of the protected-mode descriptor table. A per-vector bitmap, held inside the unit, says which vectors are intercepted. Each request ends in one of three outcomes: the guest's own real-mode vector table at address 0 of the task's space, the protected-mode descriptor table, or a general-protection fault.

The bitmap holds one bit per vector and is loaded one 32-bit word at a time through a write port whose index counts words up from the start of the bitmap. Requests are captured on a clock edge. The outcome and the table entry address are presented in the following cycle, together with a one-cycle valid pulse.

Top module: `swint_router`

## Requirements
- R1: After reset `rsp_valid` is 0, `rsp_route` is 2'b00 and `rsp_addr` is 0, and every bitmap bit is clear.
- R2: A request with `req_valid` high at a clock edge gives `rsp_valid` high for exactly the next cycle; with `req_valid` low, `rsp_valid` is low in the next cycle, and `rsp_route`/`rsp_addr` read 0 whenever `rsp_valid` is low.
- R3: When `req_vm` is 0, the outcome is descriptor-table dispatch (route 2'b10), whatever the bitmap, enable and privilege level.
- R4: In virtual-machine mode with the extension enabled and the vector's bitmap bit clear, the outcome is real-mode table dispatch (route 2'b01) with address vector × 4.
- R5: In virtual-machine mode with the vector's bitmap bit set and privilege level 3, the outcome is descriptor-table dispatch with address `idt_base` + vector × 8.
- R6: In virtual-machine mode with the extension disabled and privilege level 3, the outcome is descriptor-table dispatch regardless of the bitmap bit.
- R7: In virtual-machine mode with the extension disabled or the bitmap bit set, a privilege level below 3 gives a fault (route 2'b11) with address 0.
- R8: Bitmap word k (index 0..7) bit j controls vector 32·k + j, so bit 0 of word 0 is vector 0 and bit 31 of word 7 is vector 255.
- R9: A bitmap write replaces only the addressed word at the next clock edge; a response presented in the same cycle as the write still uses the old bitmap contents.
- R10: The descriptor-table address is computed modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, captured at the clock edge |
| req_vector | input | 8 | Software interrupt vector |
| req_iopl | input | 2 | Current I/O privilege level |
| req_vm | input | 1 | 1 when the task runs in virtual-machine mode |
| req_ext_en | input | 1 | Virtual-machine extension enable |
| idt_base | input | 32 | Base address of the protected-mode descriptor table |
| bm_wr_en | input | 1 | Bitmap word write strobe |
| bm_wr_idx | input | 3 | Bitmap word index, counted from the bitmap base |
| bm_wr_data | input | 32 | Bitmap word value |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_route | output | 2 | 01 real table, 10 descriptor table, 11 fault, 00 idle |
| rsp_addr | output | 32 | Table entry address; 0 for a fault |

## Verification
On every cycle the assertions check the pulse shape of `rsp_valid`, that a request outside virtual-machine mode is always sent to the descriptor table, that the real-mode table is never chosen without both mode and enable, that privilege level 3 never faults, the shape of real-table and fault addresses, and that the bitmap holds still without a write. Which bitmap bit governs which vector, the exact descriptor addresses including wrap-around, and the old-contents behaviour of a write overlapping a response are only shown by the bench's directed scenarios, which track a shadow bitmap.

// File: rtl/swir_pkg.sv
package swir_pkg;

   typedef enum logic [1:0] {
      ROUTE_NONE  = 2'b00,
      ROUTE_REAL  = 2'b01,
      ROUTE_DESC  = 2'b10,
      ROUTE_FAULT = 2'b11
   } route_e;

   localparam logic [1:0] PRIV_OPEN = 2'd3;

endpackage

// File: rtl/swir_bitmap.sv
module swir_bitmap #(
   parameter int VEC_W  = 8,
   parameter int WORD_W = 32,
   localparam int NUM_VEC   = 1 << VEC_W,
   localparam int NUM_WORDS = NUM_VEC / WORD_W,
   localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [VEC_W-1:0]  rd_vec,
   output logic              rd_bit
);

   if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0 || WORD_W > NUM_VEC) begin : g_bad_word
      initial $fatal(1, "swir_bitmap: WORD_W must be a power of two between 8 and 2**VEC_W");
   end

   logic [NUM_VEC-1:0] flat;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(w))
            word_q <= wr_data;
      end
      assign flat[w*WORD_W +: WORD_W] = word_q;
   end

   assign rd_bit = flat[rd_vec];

   // R9: without a write strobe the stored bitmap does not move
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(flat));

endmodule

// File: rtl/swir_decide.sv
module swir_decide
   import swir_pkg::*;
(
   input  logic       vm,
   input  logic       ext_en,
   input  logic       map_bit,
   input  logic [1:0] iopl,
   output route_e     route
);

   logic intercept;

   // legacy path is taken when the extension is off or the vector is marked
   assign intercept = !ext_en || map_bit;

   always_comb begin
      if (!vm)
         route = ROUTE_DESC;
      else if (!intercept)
         route = ROUTE_REAL;
      else if (iopl == PRIV_OPEN)
         route = ROUTE_DESC;
      else
         route = ROUTE_FAULT;
   end

endmodule

// File: rtl/swir_addr.sv
module swir_addr
   import swir_pkg::*;
#(
   parameter int VEC_W      = 8,
   parameter int ADDR_W     = 32,
   parameter int REAL_SHIFT = 2,
   parameter int DESC_SHIFT = 3
) (
   input  route_e             route,
   input  logic [VEC_W-1:0]   vec,
   input  logic [ADDR_W-1:0]  base,
   output logic [ADDR_W-1:0]  addr
);

   if (ADDR_W < VEC_W + DESC_SHIFT || ADDR_W < VEC_W + REAL_SHIFT) begin : g_bad_addr
      initial $fatal(1, "swir_addr: ADDR_W too narrow for the scaled vector");
   end

   logic [ADDR_W-1:0] vec_ext;
   logic [ADDR_W-1:0] real_off;
   logic [ADDR_W-1:0] desc_off;

   assign vec_ext  = ADDR_W'(vec);
   assign real_off = vec_ext << REAL_SHIFT;
   assign desc_off = vec_ext << DESC_SHIFT;

   always_comb begin
      unique case (route)
         ROUTE_REAL: addr = real_off;
         ROUTE_DESC: addr = base + desc_off;
         default:    addr = '0;
      endcase
   end

endmodule

// File: rtl/swint_router.sv
module swint_router
   import swir_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int WORD_W = 32,
   parameter int ADDR_W = 32,
   localparam int NUM_VEC   = 1 << VEC_W,
   localparam int NUM_WORDS = NUM_VEC / WORD_W,
   localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VEC_W-1:0]  req_vector,
   input  logic [1:0]        req_iopl,
   input  logic              req_vm,
   input  logic              req_ext_en,
   input  logic [ADDR_W-1:0] idt_base,
   input  logic              bm_wr_en,
   input  logic [IDX_W-1:0]  bm_wr_idx,
   input  logic [WORD_W-1:0] bm_wr_data,
   output logic              rsp_valid,
   output logic [1:0]        rsp_route,
   output logic [ADDR_W-1:0] rsp_addr
);

   logic              valid_q;
   logic [VEC_W-1:0]  vec_q;
   logic [1:0]        iopl_q;
   logic              vm_q;
   logic              ext_q;
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         vec_q   <= '0;
         iopl_q  <= '0;
         vm_q    <= 1'b0;
         ext_q   <= 1'b0;
         base_q  <= '0;
      end else begin
         valid_q <= req_valid;
         if (req_valid) begin
            vec_q  <= req_vector;
            iopl_q <= req_iopl;
            vm_q   <= req_vm;
            ext_q  <= req_ext_en;
            base_q <= idt_base;
         end
      end
   end

   logic              map_bit;
   route_e            route;
   logic [ADDR_W-1:0] addr;

   swir_bitmap #(.VEC_W(VEC_W), .WORD_W(WORD_W)) i_bitmap (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bm_wr_en),
      .wr_idx  (bm_wr_idx),
      .wr_data (bm_wr_data),
      .rd_vec  (vec_q),
      .rd_bit  (map_bit)
   );

   swir_decide i_decide (
      .vm      (vm_q),
      .ext_en  (ext_q),
      .map_bit (map_bit),
      .iopl    (iopl_q),
      .route   (route)
   );

   swir_addr #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) i_addr (
      .route (route),
      .vec   (vec_q),
      .base  (base_q),
      .addr  (addr)
   );

   assign rsp_valid = valid_q;
   assign rsp_route = valid_q ? route : ROUTE_NONE;
   assign rsp_addr  = valid_q ? addr  : '0;

   // R2: one result strobe per request, none otherwise
   p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R3: outside virtual-machine mode the descriptor table is used
   p_native_desc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_vm) |=> rsp_route == ROUTE_DESC);

   // R4: guest table only with mode and extension both on; entries are 4-byte aligned below 1 KiB
   p_real_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(req_vm && req_ext_en)) |=> rsp_route != ROUTE_REAL);
   p_real_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_route == ROUTE_REAL) |->
         (rsp_addr[1:0] == 2'b00 && (rsp_addr >> (VEC_W + 2)) == '0));

   // R7: full privilege never faults, and a fault carries no address
   p_open_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_iopl == PRIV_OPEN) |=> rsp_route != ROUTE_FAULT);
   p_fault_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_route == ROUTE_FAULT) |-> rsp_addr == '0);

endmodule

// File: tb/test_swint_router.sv
`timescale 1ns/1ps
module test_swint_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vector = '0;
   logic [1:0]  req_iopl = '0;
   logic        req_vm = 1'b0;
   logic        req_ext_en = 1'b0;
   logic [31:0] idt_base = '0;
   logic        bm_wr_en = 1'b0;
   logic [2:0]  bm_wr_idx = '0;
   logic [31:0] bm_wr_data = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_route;
   logic [31:0] rsp_addr;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;
   logic [255:0] shadow = '0;

   always #2 clk = ~clk;

   swint_router i_swint_router (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vector(req_vector), .req_iopl(req_iopl),
      .req_vm(req_vm), .req_ext_en(req_ext_en), .idt_base(idt_base),
      .bm_wr_en(bm_wr_en), .bm_wr_idx(bm_wr_idx), .bm_wr_data(bm_wr_data),
      .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_addr(rsp_addr)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] model_route(logic vm, logic ext, logic b, logic [1:0] iopl);
      if (!vm) return 2'b10;
      if (ext && !b) return 2'b01;
      if (iopl == 2'd3) return 2'b10;
      return 2'b11;
   endfunction

   function automatic logic [31:0] model_addr(logic [1:0] r, logic [7:0] v, logic [31:0] base);
      if (r == 2'b01) return {22'd0, v, 2'b00};
      if (r == 2'b10) return base + {21'd0, v, 3'b000};
      return 32'd0;
   endfunction

   task automatic bm_write(logic [2:0] idx, logic [31:0] data);
      @(negedge clk);
      bm_wr_en = 1'b1; bm_wr_idx = idx; bm_wr_data = data;
      @(negedge clk);
      bm_wr_en = 1'b0;
      shadow[idx*32 +: 32] = data;
   endtask

   task automatic do_req(string tag, logic [7:0] v, logic [1:0] iopl,
                         logic vm, logic ext, logic [31:0] base);
      logic [1:0] er;
      er = model_route(vm, ext, shadow[v], iopl);
      @(negedge clk);
      req_valid = 1'b1; req_vector = v; req_iopl = iopl;
      req_vm = vm; req_ext_en = ext; idt_base = base;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " valid"}, 32'(rsp_valid), 32'd1);
      check({tag, " route"}, 32'(rsp_route), 32'(er));
      check({tag, " addr"}, rsp_addr, model_addr(er, v, base));
      @(negedge clk);
      check("R2 pulse end", 32'(rsp_valid), 32'd0);
      check("R2 idle route", 32'(rsp_route), 32'd0);
   endtask

   task automatic t_reset;
      check("R1 valid", 32'(rsp_valid), 32'd0);
      check("R1 route", 32'(rsp_route), 32'd0);
      check("R1 addr", rsp_addr, 32'd0);
      // empty bitmap: every tested vector stays in the guest table
      do_req("R1 clear map v0", 8'd0, 2'd0, 1'b1, 1'b1, 32'h1000);
      do_req("R1 clear map v255", 8'd255, 2'd0, 1'b1, 1'b1, 32'h1000);
   endtask

   task automatic t_guest_table;
      do_req("R4 v21", 8'h21, 2'd0, 1'b1, 1'b1, 32'h2000);
      do_req("R4 v80 iopl3", 8'h80, 2'd3, 1'b1, 1'b1, 32'h2000);
   endtask

   task automatic t_native;
      bm_write(3'd2, 32'hFFFF_FFFF);
      do_req("R3 iopl0", 8'h45, 2'd0, 1'b0, 1'b1, 32'h0004_0000);
      do_req("R3 ext off", 8'h10, 2'd1, 1'b0, 1'b0, 32'h0004_0000);
   endtask

   task automatic t_intercept;
      bm_write(3'd4, 32'h0000_0001);
      do_req("R5 v80 iopl3", 8'h80, 2'd3, 1'b1, 1'b1, 32'h0010_0000);
      do_req("R7 v80 iopl2", 8'h80, 2'd2, 1'b1, 1'b1, 32'h0010_0000);
      do_req("R4 v81 neighbour", 8'h81, 2'd2, 1'b1, 1'b1, 32'h0010_0000);
   endtask

   task automatic t_ext_off;
      do_req("R6 clear bit", 8'h05, 2'd3, 1'b1, 1'b0, 32'h0000_8000);
      do_req("R6 set bit", 8'h80, 2'd3, 1'b1, 1'b0, 32'h0000_8000);
      do_req("R7 ext off iopl0", 8'h05, 2'd0, 1'b1, 1'b0, 32'h0000_8000);
   endtask

   task automatic t_bit_order;
      bm_write(3'd0, 32'h8000_0000);
      bm_write(3'd1, 32'h0000_0001);
      bm_write(3'd7, 32'h8000_0000);
      do_req("R8 v31", 8'd31, 2'd1, 1'b1, 1'b1, 32'h0);
      do_req("R8 v32", 8'd32, 2'd1, 1'b1, 1'b1, 32'h0);
      do_req("R8 v30", 8'd30, 2'd1, 1'b1, 1'b1, 32'h0);
      do_req("R8 v33", 8'd33, 2'd1, 1'b1, 1'b1, 32'h0);
      do_req("R8 v255", 8'd255, 2'd3, 1'b1, 1'b1, 32'h0300_0000);
      do_req("R8 v254", 8'd254, 2'd3, 1'b1, 1'b1, 32'h0300_0000);
   endtask

   task automatic t_write_overlap;
      // vector 0x66 lives in word 3 bit 6
      @(negedge clk);
      req_valid = 1'b1; req_vector = 8'h66; req_iopl = 2'd3;
      req_vm = 1'b1; req_ext_en = 1'b1; idt_base = 32'h5000;
      @(negedge clk);
      req_valid = 1'b0;
      bm_wr_en = 1'b1; bm_wr_idx = 3'd3; bm_wr_data = 32'h0000_0040;
      #0.5;
      check("R9 old contents route", 32'(rsp_route), 32'h1);
      check("R9 old contents addr", rsp_addr, 32'h0000_0198);
      @(negedge clk);
      bm_wr_en = 1'b0;
      shadow[3*32 +: 32] = 32'h0000_0040;
      do_req("R9 new contents", 8'h66, 2'd3, 1'b1, 1'b1, 32'h5000);
      do_req("R9 other word kept", 8'h80, 2'd3, 1'b1, 1'b1, 32'h5000);
   endtask

   task automatic t_wrap;
      do_req("R10 wrap", 8'h40, 2'd3, 1'b0, 1'b0, 32'hFFFF_FF00);
      check("R10 wrapped value", model_addr(2'b10, 8'h40, 32'hFFFF_FF00), 32'h0000_0100);
   endtask

   initial begin
      #1;
      check("R1 valid in reset", 32'(rsp_valid), 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_guest_table();
      t_native();
      t_intercept();
      t_ext_off();
      t_bit_order();
      t_write_overlap();
      t_wrap();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule